// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block multiplies two 32-bit operands and keeps the low 32 bits of the product. It can also add a third operand to that product, with wraparound. A caller raises `start` for one cycle while the block is idle. With that pulse it presents four register indices (destination, accumulator, multiplicand, multiplier), the three operand values, an accumulate enable and a flag-update enable. The block then stays busy for a number of cycles that depends on the operation. After that it pulses `done` for one cycle and reports the result, the write strobe, the illegal indication and the number of cycles consumed.

The latency has three parts: one base cycle, a multiplier-array count taken from the magnitude of the multiplier, and one more cycle when accumulation is on. Some index combinations are rejected: any index that names the program counter (index 15), or a destination that equals the multiplicand index. A rejected operation completes after one cycle, writes nothing and leaves the flags untouched.

Top module: `mac_unit`

## Requirements
- R1: With accumulate off, `result` at `done` equals the low 32 bits of `opMcand * opMplier`, and `result` changes only in a cycle where `done` is high.
- R2: With accumulate on, `result` equals `opMcand * opMplier + opAcc` modulo 2^32.
- R3: If any of the four indices equals 15, the operation completes with `illegal`=1 and `destWr`=0, and `result`, `flagN` and `flagZ` keep their previous values.
- R4: If `idxDest` equals `idxMcand`, the operation completes as illegal, with the same effects as R3.
- R5: On a legal operation with `setFlags`=1, `flagN` becomes result bit 31 and `flagZ` becomes 1 exactly when the result is zero. With `setFlags`=0, both flags keep their values.
- R6: A legal operation keeps `busy` high for L = 1 + M + (accumulate ? 1 : 0) cycles, then pulses `done`, and `cyclesUsed` reports L. An illegal operation takes L = 1.
- R7: M is derived from the multiplier as follows. M=1 if bits 31:8 are all zeros or all ones. Otherwise M=2 if bits 31:16 are, M=3 if bits 31:24 are, and M=4 in every other case.
- R8: A `start` raised while `busy` is high is ignored: the running operation's result and latency are unchanged, and no extra `done` follows.
- R9: After reset, `busy`, `done`, `destWr`, `illegal`, `flagN` and `flagZ` are 0, and `result` and `cyclesUsed` are 0.
- R10: `done` is high for one cycle per accepted operation. `destWr` is high only in that cycle, and only for a legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| idxDest | input | 4 | Destination register index |
| idxAcc | input | 4 | Accumulator register index |
| idxMcand | input | 4 | Multiplicand register index |
| idxMplier | input | 4 | Multiplier register index |
| opMcand | input | 32 | Multiplicand value |
| opMplier | input | 32 | Multiplier value |
| opAcc | input | 32 | Accumulator value |
| accEn | input | 1 | Add the accumulator |
| setFlags | input | 1 | Update the negative and zero flags |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Last written result |
| destWr | output | 1 | Destination write strobe, coincides with done |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| illegal | output | 1 | Last completed operation was rejected |
| cyclesUsed | output | 3 | Busy cycles of the last completed operation |

## Verification
The multiplier is chosen at both edges of every array-count band, with positive and negative values (255 against 256, -256 against -257, and so on up to the top byte). Each band boundary therefore shows up as a one-cycle step in the measured latency. Multiplicands that overflow 32 bits and accumulators that wrap past zero separate true truncation from a wider sum. Zero and negative results, each with flag update on and off, separate a flag write from a held flag. Each index position set to 15 in turn, plus destination-equals-multiplicand, shows that every rejection path suppresses the write. A second start raised during a long operation shows that it is ignored.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands and decode
    logic commit;  // final busy cycle: write outputs
  } macCtl_t;
endpackage

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15,
  parameter int STEP   = 8,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  macCtl_t          ctl,
  input  logic [IDX_W-1:0] idxDest,
  input  logic [IDX_W-1:0] idxAcc,
  input  logic [IDX_W-1:0] idxMcand,
  input  logic [IDX_W-1:0] idxMplier,
  input  logic [WIDTH-1:0] opMcand,
  input  logic [WIDTH-1:0] opMplier,
  input  logic [WIDTH-1:0] opAcc,
  input  logic             accEn,
  input  logic             setFlags,
  output logic [CNT_W-1:0] latency,
  output logic [WIDTH-1:0] result,
  output logic             destWr,
  output logic             flagN,
  output logic             flagZ,
  output logic             illegal,
  output logic [CNT_W-1:0] cyclesUsed
);
  localparam int NUM_STAGES = WIDTH / STEP;
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

  // decode of incoming request
  logic                 illegalIn;
  logic [NUM_STAGES-1:1] fits;
  logic [CNT_W-1:0]     arrayCnt;

  assign illegalIn = (idxDest == PC_SEL) || (idxAcc == PC_SEL) ||
                     (idxMcand == PC_SEL) || (idxMplier == PC_SEL) ||
                     (idxDest == idxMcand);

  // upper bits above each byte boundary: all zeros or all ones
  genvar k;
  generate
    for (k = 1; k < NUM_STAGES; k++) begin : g_fit
      assign fits[k] = (&opMplier[WIDTH-1:STEP*k]) | ~(|opMplier[WIDTH-1:STEP*k]);
    end
  endgenerate

  always_comb begin
    arrayCnt = CNT_W'(NUM_STAGES);
    for (int j = NUM_STAGES - 1; j >= 1; j--) begin
      if (fits[j]) arrayCnt = CNT_W'(j);
    end
  end

  assign latency = illegalIn ? CNT_W'(1) : (arrayCnt + CNT_W'(accEn) + CNT_W'(1));

  // captured operation
  logic [WIDTH-1:0] mcandQ, mplierQ, accQ;
  logic             accEnQ, setFlagsQ, illegalQ;
  logic [CNT_W-1:0] latQ;
  logic [WIDTH-1:0] prodW, sumW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mcandQ    <= '0;
      mplierQ   <= '0;
      accQ      <= '0;
      accEnQ    <= 1'b0;
      setFlagsQ <= 1'b0;
      illegalQ  <= 1'b0;
      latQ      <= '0;
    end else if (ctl.load) begin
      mcandQ    <= opMcand;
      mplierQ   <= opMplier;
      accQ      <= opAcc;
      accEnQ    <= accEn;
      setFlagsQ <= setFlags;
      illegalQ  <= illegalIn;
      latQ      <= latency;
    end
  end

  assign prodW = mcandQ * mplierQ;
  assign sumW  = prodW + (accEnQ ? accQ : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result     <= '0;
      destWr     <= 1'b0;
      flagN      <= 1'b0;
      flagZ      <= 1'b0;
      illegal    <= 1'b0;
      cyclesUsed <= '0;
    end else begin
      destWr <= 1'b0;
      if (ctl.commit) begin
        illegal    <= illegalQ;
        cyclesUsed <= latQ;
        if (!illegalQ) begin
          result <= sumW;
          destWr <= 1'b1;
          if (setFlagsQ) begin
            flagN <= sumW[WIDTH-1];
            flagZ <= (sumW == '0);
          end
        end
      end
    end
  end

  AST_ILLEGAL_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && illegalQ) |=> ($stable(result) && !destWr)); // R3
endmodule

// File: rtl/mac_control.sv
module mac_control
  import mac_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] latency,
  output macCtl_t          ctl,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] remain;
  logic             busyQ;

  always_comb begin
    ctl.load   = start && !busyQ;
    ctl.commit = busyQ && (remain == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctl.commit;
      if (ctl.load) begin
        busyQ  <= 1'b1;
        remain <= latency - CNT_W'(1);
      end else if (ctl.commit) begin
        busyQ <= 1'b0;
      end else if (busyQ) begin
        remain <= remain - CNT_W'(1);
      end
    end
  end

  assign busy = busyQ;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_LATENCY_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> (latency != '0)); // R6
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15,
  parameter int STEP   = 8,
  parameter int CNT_W  = $clog2(WIDTH / STEP + 3)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] idxDest,
  input  logic [IDX_W-1:0] idxAcc,
  input  logic [IDX_W-1:0] idxMcand,
  input  logic [IDX_W-1:0] idxMplier,
  input  logic [WIDTH-1:0] opMcand,
  input  logic [WIDTH-1:0] opMplier,
  input  logic [WIDTH-1:0] opAcc,
  input  logic             accEn,
  input  logic             setFlags,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             destWr,
  output logic             flagN,
  output logic             flagZ,
  output logic             illegal,
  output logic [CNT_W-1:0] cyclesUsed
);
  localparam int MAX_LAT = WIDTH / STEP + 2;

  macCtl_t          ctl;
  logic [CNT_W-1:0] latency;

  mac_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .latency(latency),
    .ctl    (ctl),
    .busy   (busy),
    .done   (done)
  );

  mac_datapath #(
    .WIDTH (WIDTH),
    .IDX_W (IDX_W),
    .PC_IDX(PC_IDX),
    .STEP  (STEP),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .idxDest   (idxDest),
    .idxAcc    (idxAcc),
    .idxMcand  (idxMcand),
    .idxMplier (idxMplier),
    .opMcand   (opMcand),
    .opMplier  (opMplier),
    .opAcc     (opAcc),
    .accEn     (accEn),
    .setFlags  (setFlags),
    .latency   (latency),
    .result    (result),
    .destWr    (destWr),
    .flagN     (flagN),
    .flagZ     (flagZ),
    .illegal   (illegal),
    .cyclesUsed(cyclesUsed)
  );

  AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    destWr |-> done); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result)); // R1
  AST_CYCLES_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cyclesUsed >= CNT_W'(1) && cyclesUsed <= CNT_W'(MAX_LAT))); // R6
  AST_ZFLAG_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (flagZ != $past(flagZ)) |-> (flagZ == (result == '0))); // R5
  AST_NFLAG_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (flagN != $past(flagN)) |-> (flagN == result[WIDTH-1])); // R5
endmodule

// File: tb/sim_mac_unit.sv
`timescale 1ns/1ps
module sim_mac_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  idxDest = 4'd1, idxAcc = 4'd2, idxMcand = 4'd3, idxMplier = 4'd4;
  logic [31:0] opMcand = '0, opMplier = '0, opAcc = '0;
  logic        accEn = 1'b0, setFlags = 1'b0;
  logic        busy, done, destWr, flagN, flagZ, illegal;
  logic [31:0] result;
  logic [2:0]  cyclesUsed;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mac_unit u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .idxDest(idxDest), .idxAcc(idxAcc), .idxMcand(idxMcand), .idxMplier(idxMplier),
    .opMcand(opMcand), .opMplier(opMplier), .opAcc(opAcc),
    .accEn(accEn), .setFlags(setFlags),
    .busy(busy), .done(done), .result(result), .destWr(destWr),
    .flagN(flagN), .flagZ(flagZ), .illegal(illegal), .cyclesUsed(cyclesUsed)
  );

  // fields: mcand, mplier, acc, accEn, setFlags
  localparam int NV = 12;
  localparam logic [97:0] VEC [NV] = '{
    {32'd3,          32'd5,          32'd0,          1'b0, 1'b1},
    {32'd7,          32'd255,        32'd0,          1'b0, 1'b1},
    {32'd7,          32'd256,        32'd0,          1'b0, 1'b0},
    {32'hFFFF_FFFF,  32'hFFFF_FF00,  32'd0,          1'b0, 1'b1},
    {32'd2,          32'hFFFF_FEFF,  32'd0,          1'b0, 1'b1},
    {32'd3,          32'h0000_FFFF,  32'd10,         1'b1, 1'b1},
    {32'd3,          32'h0001_0000,  32'd0,          1'b0, 1'b1},
    {32'd1,          32'hFF00_0000,  32'd0,          1'b0, 1'b1},
    {32'd1,          32'h0100_0000,  32'd0,          1'b1, 1'b1},
    {32'h0001_0000,  32'h0001_0000,  32'd0,          1'b1, 1'b1},
    {32'hFFFF_FFFF,  32'd1,          32'd2,          1'b1, 1'b1},
    {32'h8000_0001,  32'h7654_3210,  32'h1234_5678,  1'b1, 1'b0}
  };

  logic expN = 1'b0, expZ = 1'b0;
  logic [31:0] expRes = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R7 band by signed range of the multiplier
  function automatic int expM(input logic [31:0] v);
    int s = signed'(v);
    if (s >= -256 && s < 256) return 1;
    if (s >= -65536 && s < 65536) return 2;
    if (s >= -(1 << 24) && s < (1 << 24)) return 3;
    return 4;
  endfunction

  // start one op and wait for done; counts busy cycles
  task automatic runOp(output int nBusy, output bit sawWr, output bit gotDone);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nBusy = 0; sawWr = 0; gotDone = 0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin
        gotDone = 1; sawWr = destWr;
        break;
      end
      if (busy) nBusy++;
      @(negedge clk);
    end
  endtask

  task automatic setOp(input logic [3:0] d, input logic [3:0] a, input logic [3:0] mc,
                       input logic [3:0] mp, input logic [31:0] vMc, input logic [31:0] vMp,
                       input logic [31:0] vA, input logic ae, input logic sf);
    idxDest = d; idxAcc = a; idxMcand = mc; idxMplier = mp;
    opMcand = vMc; opMplier = vMp; opAcc = vA; accEn = ae; setFlags = sf;
  endtask

  task automatic checkIllegal(input string req);
    int nb; bit wr, gd;
    runOp(nb, wr, gd);
    chk(gd, req, "illegal op done", 32'(gd), 32'd1);
    chk(illegal, req, "illegal flag", 32'(illegal), 32'd1);
    chk(!wr, req, "no dest write", 32'(wr), 32'd0);
    chk(result == expRes, req, "result kept", result, expRes);
    chk(flagN == expN && flagZ == expZ, req, "flags kept", {30'd0, flagN, flagZ}, {30'd0, expN, expZ});
    chk(nb == 1 && cyclesUsed == 3'd1, req, "illegal latency", 32'(nb), 32'd1);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !destWr && !illegal && !flagN && !flagZ, "R9", "reset controls",
        {26'd0, busy, done, destWr, illegal, flagN, flagZ}, 32'd0);
    chk(result == 0 && cyclesUsed == 0, "R9", "reset result/cycles", result, 32'd0);
    rstN = 1'b1;

    // table walk: R1 R2 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      int nb; bit wr, gd; int lat;
      logic [31:0] mc, mp, ac, ex; logic ae, sf;
      {mc, mp, ac, ae, sf} = VEC[v];
      setOp(4'd1, 4'd2, 4'd3, 4'd4, mc, mp, ac, ae, sf);
      ex  = mc * mp + (ae ? ac : 32'd0);
      lat = 1 + expM(mp) + (ae ? 1 : 0);
      runOp(nb, wr, gd);
      chk(gd && wr && !illegal, "R10", "done with write", {29'd0, gd, wr, illegal}, 32'd6);
      chk(result == ex, ae ? "R2" : "R1", "result", result, ex);
      chk(nb == lat, "R7", "busy cycles", 32'(nb), 32'(lat));
      chk(int'(cyclesUsed) == lat, "R6", "cyclesUsed", 32'(cyclesUsed), 32'(lat));
      expRes = ex;
      if (sf) begin expN = ex[31]; expZ = (ex == 0); end
      chk(flagN == expN && flagZ == expZ, "R5", "flags", {30'd0, flagN, flagZ}, {30'd0, expN, expZ});
      @(negedge clk);
      chk(!done && !destWr, "R10", "pulse ends", {30'd0, done, destWr}, 32'd0);
    end

    // R3: each index set to 15
    setOp(4'd15, 4'd2, 4'd3, 4'd4, 32'd9, 32'd9, 32'd0, 1'b0, 1'b1); checkIllegal("R3");
    setOp(4'd1, 4'd15, 4'd3, 4'd4, 32'd9, 32'd9, 32'd0, 1'b0, 1'b1); checkIllegal("R3");
    setOp(4'd1, 4'd2, 4'd15, 4'd4, 32'd9, 32'd9, 32'd0, 1'b0, 1'b1); checkIllegal("R3");
    setOp(4'd1, 4'd2, 4'd3, 4'd15, 32'd9, 32'd9, 32'd0, 1'b0, 1'b1); checkIllegal("R3");
    // R4: dest aliases multiplicand
    setOp(4'd5, 4'd2, 4'd5, 4'd4, 32'd0, 32'd0, 32'd0, 1'b0, 1'b1); checkIllegal("R4");

    // R8: start held during a long op
    begin
      int nb; bit gd; logic [31:0] ex;
      setOp(4'd1, 4'd2, 4'd3, 4'd4, 32'd5, 32'h1234_5678, 32'd1, 1'b1, 1'b1);
      ex = 32'd5 * 32'h1234_5678 + 32'd1;
      @(negedge clk); start = 1'b1;
      @(negedge clk);
      setOp(4'd1, 4'd2, 4'd3, 4'd4, 32'd0, 32'd0, 32'd0, 1'b0, 1'b1);
      nb = 0; gd = 0;
      for (int i = 0; i < 40; i++) begin
        if (i == 2) start = 1'b0;
        if (done) begin gd = 1; break; end
        if (busy) nb++;
        @(negedge clk);
      end
      chk(gd && result == ex, "R8", "first op result", result, ex);
      chk(nb == 6, "R8", "first op latency", 32'(nb), 32'd6);
      gd = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (done || busy) gd = 1;
      end
      chk(!gd, "R8", "no second op", 32'(gd), 32'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule